// File: doc/BRIEF.md
# Programmable Almost-Full/Almost-Empty Level Flag

This block watches the stored-word count of one FIFO direction and raises a single warning flag whenever the FIFO is nearly drained or nearly filled. Two 8-bit limits set the thresholds. The low limit (X) covers the near-empty side and the high limit (Y) covers the near-full side. The flag is high when the count is X or below, or when it is DEPTH minus Y or above. The count input is expected to be already synchronized to this port's clock. The flag is a register on that clock.

Both limits start at a default value (128 for a 512-word FIFO) when reset is released. Between reset and the first accepted write, the limits can be loaded from the low bits of the port's data bus. The data is sampled on clock edges while the active-low program strobe is held low. The first such edge loads both limits with the same value. If the strobe is still low at the next edge, only the high limit is loaded again. While a load is under way, the block raises a write-block output so that the FIFO stores nothing. The programming chance closes for good when the sequence completes, when the strobe is released after a load, or when a write is accepted. It opens again only after the next reset.

Top module: `almost_level_flag`

## Requirements
- R1: One clock edge after the count is presented, the flag is 1 when count <= X or count >= DEPTH - Y, and 0 otherwise.
- R2: If the program strobe is never driven low after reset, both X and Y equal DEF_OFS (128 by default).
- R3: The first rising edge with the program strobe low in the open window loads the data value into both X and Y.
- R4: If the program strobe stays low for the next rising edge, only Y is loaded, from the data present at that edge. X keeps its first value.
- R5: After the second programming edge, or once the strobe has returned high after a first load, further low levels on the strobe change neither limit until reset.
- R6: Once a write is accepted, the programming window stays closed until the next reset, and later strobe activity leaves the defaults in place.
- R7: The write-block output is 1 while the program strobe is low and the window is open, and 0 otherwise, including after the window has closed.
- R8: While reset is asserted the flag is forced to 1, whatever the count. Each reset restores the default limits.
- R9: Each limit is OFS_W bits wide, so the all-ones value (255 by default) is a legal setting and is compared correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Active-low limit program strobe |
| din | input | OFS_W | Data bus bits used as the limit value |
| wr_accept | input | 1 | High for one cycle for each word the FIFO accepts |
| level | input | CNT_W | Synchronized stored-word count, 0 to DEPTH |
| flag | output | 1 | Registered almost-empty/almost-full flag |
| wr_block | output | 1 | High while limit programming holds off FIFO writes |

## Verification
The assertions rely on the count never going above DEPTH, and on the FIFO never accepting a write in a cycle where write-block is high. The bench keeps to both rules: it sweeps the count only from 0 to DEPTH, and it pulses the write strobe only while the program strobe is high. The bench uses a 32-word configuration with 4-bit limits. In that configuration every count value is swept under the default, single-load, two-load, maximum-value and locked-out limit settings.

// File: rtl/aff_pkg.sv
package aff_pkg;
  typedef enum logic {
    PH_FRESH  = 1'b0,
    PH_SECOND = 1'b1
  } prog_phase_e;
endpackage

// File: rtl/aff_offset_prog.sv
module aff_offset_prog
  import aff_pkg::*;
#(
  parameter int OFS_W   = 8,
  parameter int DEF_OFS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic [OFS_W-1:0] din,
  input  logic             wr_accept,
  output logic [OFS_W-1:0] x_ofs,
  output logic [OFS_W-1:0] y_ofs,
  output logic             wr_block
);
  localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(DEF_OFS);

  logic             win_q, win_d;
  prog_phase_e      ph_q, ph_d;
  logic [OFS_W-1:0] x_q, x_d, y_q, y_d;

  // next-state logic
  always_comb begin
    win_d = win_q;
    ph_d  = ph_q;
    x_d   = x_q;
    y_d   = y_q;
    if (win_q) begin
      if (wr_accept) begin
        win_d = 1'b0;
      end else if (!prog_n) begin
        if (ph_q == PH_FRESH) begin
          x_d  = din;
          y_d  = din;
          ph_d = PH_SECOND;
        end else begin
          y_d   = din;
          win_d = 1'b0;
        end
      end else if (ph_q == PH_SECOND) begin
        win_d = 1'b0;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b1;
      ph_q  <= PH_FRESH;
      x_q   <= DEF_VAL;
      y_q   <= DEF_VAL;
    end else begin
      win_q <= win_d;
      ph_q  <= ph_d;
      x_q   <= x_d;
      y_q   <= y_d;
    end
  end

  assign x_ofs    = x_q;
  assign y_ofs    = y_q;
  assign wr_block = win_q && !prog_n;

  // R6
  write_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !win_q);

  // R5
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_q |=> ($stable(x_ofs) && $stable(y_ofs)));

  // R3
  first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !prog_n && !wr_accept && ph_q == PH_FRESH)
      |=> (x_ofs == $past(din) && y_ofs == $past(din)));

  // R4
  second_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !prog_n && !wr_accept && ph_q == PH_SECOND)
      |=> (y_ofs == $past(din) && $stable(x_ofs)));

  // R7
  no_write_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_accept && wr_block));
endmodule

// File: rtl/aff_threshold.sv
module aff_threshold #(
  parameter int DEPTH = 512,
  parameter int OFS_W = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] level,
  input  logic [OFS_W-1:0] x_ofs,
  input  logic [OFS_W-1:0] y_ofs,
  output logic             hit
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] lo_lim;
  logic [CNT_W-1:0] hi_lim;

  always_comb begin
    lo_lim = CNT_W'(x_ofs);
    hi_lim = DEPTH_C - CNT_W'(y_ofs);
    hit    = (level <= lo_lim) || (level >= hi_lim);
  end
endmodule

// File: rtl/almost_level_flag.sv
module almost_level_flag #(
  parameter int DEPTH   = 512,
  parameter int OFS_W   = 8,
  parameter int DEF_OFS = 128,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic [OFS_W-1:0] din,
  input  logic             wr_accept,
  input  logic [CNT_W-1:0] level,
  output logic             flag,
  output logic             wr_block
);
  logic [OFS_W-1:0] x_ofs;
  logic [OFS_W-1:0] y_ofs;
  logic             flag_d;
  logic             flag_q;

  aff_offset_prog #(
    .OFS_W  (OFS_W),
    .DEF_OFS(DEF_OFS)
  ) u_prog (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_n   (prog_n),
    .din      (din),
    .wr_accept(wr_accept),
    .x_ofs    (x_ofs),
    .y_ofs    (y_ofs),
    .wr_block (wr_block)
  );

  aff_threshold #(
    .DEPTH(DEPTH),
    .OFS_W(OFS_W),
    .CNT_W(CNT_W)
  ) u_cmp (
    .level(level),
    .x_ofs(x_ofs),
    .y_ofs(y_ofs),
    .hit  (flag_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R1
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> flag);

  // R1
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CNT_W'(DEPTH)) |=> flag);

  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));
endmodule

// File: tb/almost_level_flag_test.sv
module almost_level_flag_test;
  localparam int DEPTH   = 32;
  localparam int OFS_W   = 4;
  localparam int DEF_OFS = 8;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             prog_n = 1'b1;
  logic [OFS_W-1:0] din = '0;
  logic             wr_accept = 1'b0;
  logic [CNT_W-1:0] level = '0;
  logic             flag;
  logic             wr_block;

  int n_chk = 0;
  int n_bad = 0;

  almost_level_flag #(
    .DEPTH(DEPTH), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .din(din),
    .wr_accept(wr_accept), .level(level), .flag(flag), .wr_block(wr_block)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    prog_n = 1'b1;
    wr_accept = 1'b0;
    level = CNT_W'(DEPTH / 2);
    @(negedge clk);
    @(negedge clk);
    check("R8 flag in reset", int'(flag), 1);
    rst_n = 1'b1;
  endtask

  task automatic sweep(input string req, input int x, input int y);
    for (int c = 0; c <= DEPTH; c++) begin
      level = CNT_W'(c);
      @(negedge clk);
      check(req, int'(flag), int'((c <= x) || (c >= DEPTH - y)));
    end
  endtask

  task automatic prog_edge(input int v);
    prog_n = 1'b0;
    din = OFS_W'(v);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R2 defaults, R1 sweep
    do_reset();
    sweep("R2 R1 default", DEF_OFS, DEF_OFS);

    // R3 single load
    do_reset();
    prog_n = 1'b0; din = 4'd5; #1;
    check("R7 wr_block open", int'(wr_block), 1);
    @(negedge clk);
    prog_n = 1'b1;
    #1 check("R7 wr_block released", int'(wr_block), 0);
    sweep("R3 single load", 5, 5);

    // R4 second edge reloads Y only, R5 third edge ignored
    do_reset();
    prog_edge(3);
    prog_edge(11);
    din = 4'd7;
    #1 check("R5 wr_block after two edges", int'(wr_block), 0);
    @(negedge clk);
    prog_n = 1'b1;
    sweep("R4 R5 two loads", 3, 11);

    // R5 relowering after release has no effect
    do_reset();
    prog_edge(5);
    prog_n = 1'b1;
    @(negedge clk);
    prog_edge(12);
    prog_n = 1'b1;
    sweep("R5 relower ignored", 5, 5);

    // R6 write closes the window; R8 defaults restored by reset
    do_reset();
    wr_accept = 1'b1;
    @(negedge clk);
    wr_accept = 1'b0;
    prog_n = 1'b0; din = 4'd2; #1;
    check("R7 wr_block after write", int'(wr_block), 0);
    @(negedge clk);
    @(negedge clk);
    prog_n = 1'b1;
    sweep("R6 R8 locked defaults", DEF_OFS, DEF_OFS);

    // R9 maximum limit values
    do_reset();
    prog_edge(15);
    prog_edge(15);
    prog_n = 1'b1;
    sweep("R9 max limits", 15, 15);

    // R9 zero limits
    do_reset();
    prog_edge(0);
    prog_n = 1'b1;
    sweep("R9 zero limits", 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule